// File: doc/BRIEF.md
# Addressing Mode Field Decoder

This block turns a 6-bit mode/register field into an addressing-mode class, a register number and a completion status. Modes that carry extension words in the instruction stream are resolved by pulling those 16-bit words one at a time over a fetch handshake. Each accepted word raises an advance count by two. The words are assembled into a 32-bit displacement or absolute address, or into up to three 32-bit immediate words.

A controller raises `start` with the field and the operand size in bytes. Modes that need no extension words complete at once, with `done` high in the same cycle. All other modes hold `fetch_req` until their last word has been accepted, and `done` pulses one cycle later. Indexed forms are only classified here. Their extension words belong to a separate decoder, so this block fetches nothing for them. An error on the fetch port ends decoding with a bus-fault status, which is distinct from the illegal-mode status.

Top module: `ea_field_decoder`

## Requirements
- R1: When field bits [5:4] are 00, the block reports class 0 (register direct) with reg_num equal to field[3:0]. It fetches no word, and `done` is high in the start cycle with status 0.
- R2: For field[5:3] equal to 2, 3, 4 or 6, the class equals that value (indirect, postincrement, predecrement, indexed) and reg_num is 8 + field[2:0]. Field 6'o73 gives class 10 (PC-relative indexed) with reg_num 3. None of these fetch a word, and `done` is high in the start cycle.
- R3: Field[5:3] = 5 (class 5, reg_num 8 + field[2:0]) and field 6'o72 (class 10's sibling, class 9, reg_num 2) each fetch one word. `disp` then holds that word sign-extended to 32 bits.
- R4: Field 6'o70 (class 7, reg_num 0) fetches one word, and `disp` holds it sign-extended. Field 6'o71 (class 8, reg_num 1) fetches two words, and `disp` = {first word, second word}.
- R5: Fields 6'o75, 6'o76 and 6'o77 (class 15), and field 6'o74 with an opsize other than 1, 2, 4, 8 or 12, are illegal. The block gives status 1 with `done` in the start cycle, fetches nothing and reports advance 0.
- R6: Field 6'o74 is immediate (class 1, reg_num 12). Opsize 1 takes one word and sets imm0 to its low byte sign-extended. Opsize 2 takes one word and sets imm0 to the word sign-extended.
- R7: An immediate of opsize 4 takes two words, with imm0 = {w0, w1}. Opsize 8 adds imm1 = {w2, w3}, and opsize 12 further adds imm2 = {w4, w5}. Unused immediate words and `disp` read 0.
- R8: `advance` is 0 after reset and after each start. It rises by 2 for every accepted word and holds its value after `done`.
- R9: If `fetch_err` is high while `fetch_req` is high, the block stops fetching. `done` pulses in the next cycle with status 2, and `advance` counts only the words accepted before the error.
- R10: `fetch_req` stays high, across any number of cycles with `fetch_ack` low, until the last required word is accepted. A word is accepted on a clock edge where `fetch_req` and `fetch_ack` are high and `fetch_err` is low. `done` pulses for one cycle right after that edge, and `fetch_req` is low from then on.
- R11: A `start` raised while `fetch_req` is high has no effect on the decode in progress or its results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin decoding the presented field (taken only when idle) |
| field | input | 6 | Mode bits [5:3], register bits [2:0] |
| opsize | input | 4 | Operand size in bytes, used for immediate mode |
| fetch_req | output | 1 | Requesting the next 16-bit extension word |
| fetch_ack | input | 1 | Extension word is present on fetch_data |
| fetch_err | input | 1 | Fetch failed; aborts the decode |
| fetch_data | input | 16 | Extension word from the instruction stream |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 illegal mode, 2 bus fault |
| mode_class | output | 4 | Decoded addressing-mode class |
| reg_num | output | 4 | Register number |
| disp | output | 32 | Displacement or absolute address |
| imm0 | output | 32 | First immediate word |
| imm1 | output | 32 | Second immediate word |
| imm2 | output | 32 | Third immediate word |
| advance | output | 8 | Bytes of extension words consumed |

## Verification
The hardest case to reach is a `start` that arrives while a multi-word fetch is stalled. Such a start must leave the class, the address and the advance count untouched. The stimulus reaches it by holding `fetch_ack` low for several cycles during an absolute-long fetch, while pulsing `start` with an illegal field. The bus-fault path needs the same kind of control. An error is injected part-way through a 12-byte immediate, after some words have already been counted, so the reported advance shows exactly where the abort took place.

// File: rtl/ea_field_decoder.sv
module ea_field_decoder #(
  parameter int ADV_W = 8,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [5:0]       field,
  input  logic [3:0]       opsize,
  output logic             fetch_req,
  input  logic             fetch_ack,
  input  logic             fetch_err,
  input  logic [15:0]      fetch_data,
  output logic             done,
  output logic [1:0]       status,
  output logic [3:0]       mode_class,
  output logic [3:0]       reg_num,
  output logic [31:0]      disp,
  output logic [31:0]      imm0,
  output logic [31:0]      imm1,
  output logic [31:0]      imm2,
  output logic [ADV_W-1:0] advance
);
  logic             busy, done_q;
  logic [CNT_W-1:0] left_q, k_q;
  logic [3:0]       cls_q, reg_q, size_q;
  logic [1:0]       st_q;
  logic [31:0]      disp_q, i0_q, i1_q, i2_q;
  logic [ADV_W-1:0] adv_q;

  logic [3:0]       d_cls, d_reg;
  logic [CNT_W-1:0] d_words;
  logic             d_bad;

  always_comb begin
    d_cls   = 4'd0;
    d_reg   = {1'b1, field[2:0]};
    d_words = '0;
    d_bad   = 1'b0;
    if (field[5:4] == 2'b00) begin
      d_reg = field[3:0];
    end else if (field == 6'o74) begin
      d_cls = 4'd1;
      case (opsize)
        4'd1, 4'd2: d_words = CNT_W'(1);
        4'd4:       d_words = CNT_W'(2);
        4'd8:       d_words = CNT_W'(4);
        4'd12:      d_words = CNT_W'(6);
        default:    d_bad   = 1'b1;
      endcase
    end else begin
      case (field[5:3])
        3'd5: begin d_cls = 4'd5; d_words = CNT_W'(1); end
        3'd7: begin
          d_reg = {1'b0, field[2:0]};
          case (field[2:0])
            3'd0:    begin d_cls = 4'd7; d_words = CNT_W'(1); end
            3'd1:    begin d_cls = 4'd8; d_words = CNT_W'(2); end
            3'd2:    begin d_cls = 4'd9; d_words = CNT_W'(1); end
            3'd3:    d_cls = 4'd10;
            default: begin d_cls = 4'd15; d_bad = 1'b1; end
          endcase
        end
        default: d_cls = {1'b0, field[5:3]};
      endcase
    end
  end

  wire go       = start && !busy;
  wire zero_now = go && (d_words == '0);
  wire accept   = busy && fetch_ack && !fetch_err;
  wire [31:0] sx16 = {{16{fetch_data[15]}}, fetch_data};
  wire [31:0] sx8  = {{24{fetch_data[7]}}, fetch_data[7:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done_q <= 1'b0; left_q <= '0; k_q <= '0;
      cls_q <= '0; reg_q <= '0; size_q <= '0; st_q <= '0;
      disp_q <= '0; i0_q <= '0; i1_q <= '0; i2_q <= '0; adv_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        cls_q  <= d_cls;
        reg_q  <= d_reg;
        size_q <= opsize;
        st_q   <= d_bad ? 2'd1 : 2'd0;
        left_q <= d_words;
        k_q    <= '0;
        busy   <= (d_words != '0);
        disp_q <= '0; i0_q <= '0; i1_q <= '0; i2_q <= '0;
        adv_q  <= '0;
      end else if (busy && fetch_err) begin
        busy   <= 1'b0;
        st_q   <= 2'd2;
        done_q <= 1'b1;
      end else if (accept) begin
        k_q    <= k_q + CNT_W'(1);
        left_q <= left_q - CNT_W'(1);
        adv_q  <= adv_q + ADV_W'(2);
        if (left_q == CNT_W'(1)) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end
        if (cls_q == 4'd1) begin
          case (k_q)
            CNT_W'(0): i0_q <= (size_q == 4'd1) ? sx8 : sx16;
            CNT_W'(1): i0_q <= {i0_q[15:0], fetch_data};
            CNT_W'(2), CNT_W'(3): i1_q <= {i1_q[15:0], fetch_data};
            default:   i2_q <= {i2_q[15:0], fetch_data};
          endcase
        end else begin
          disp_q <= (k_q == '0) ? sx16 : {disp_q[15:0], fetch_data};
        end
      end
    end
  end

  assign fetch_req  = busy;
  assign done       = done_q | zero_now;
  assign status     = zero_now ? (d_bad ? 2'd1 : 2'd0) : st_q;
  assign mode_class = zero_now ? d_cls : cls_q;
  assign reg_num    = zero_now ? d_reg : reg_q;
  assign disp       = zero_now ? 32'd0 : disp_q;
  assign imm0       = zero_now ? 32'd0 : i0_q;
  assign imm1       = zero_now ? 32'd0 : i1_q;
  assign imm2       = zero_now ? 32'd0 : i2_q;
  assign advance    = zero_now ? '0 : adv_q;
endmodule

// File: rtl/ea_field_decoder_chk.sv
module ea_field_decoder_chk #(
  parameter int ADV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [5:0]       field,
  input logic             fetch_req,
  input logic             fetch_ack,
  input logic             fetch_err,
  input logic             done,
  input logic [1:0]       status,
  input logic [3:0]       mode_class,
  input logic [3:0]       reg_num,
  input logic [ADV_W-1:0] advance
);
  assert_adv_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_ack && !fetch_err) |=> (start || advance == $past(advance) + ADV_W'(2)));

  assert_no_req_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> !done);

  assert_fault_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_err) |=> (done && status == 2'd2 && !fetch_req));

  assert_illegal_noadv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'd1) |-> (advance == '0));

  assert_direct_now_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !fetch_req && field[5:4] == 2'b00) |->
      (done && mode_class == 4'd0 && reg_num == field[3:0] && status == 2'd0));

  assert_direct_nofetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !fetch_req && field[5:4] == 2'b00) |=> !fetch_req);
endmodule

bind ea_field_decoder ea_field_decoder_chk #(.ADV_W(ADV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .field(field),
  .fetch_req(fetch_req), .fetch_ack(fetch_ack), .fetch_err(fetch_err),
  .done(done), .status(status), .mode_class(mode_class),
  .reg_num(reg_num), .advance(advance)
);

// File: tb/ea_field_decoder_tb.sv
module ea_field_decoder_tb;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [5:0] field = '0;
  logic [3:0] opsize = '0;
  logic fetch_ack = 1'b0, fetch_err = 1'b0;
  logic [15:0] fetch_data = '0;
  logic fetch_req, done;
  logic [1:0] status;
  logic [3:0] mode_class, reg_num;
  logic [31:0] disp, imm0, imm1, imm2;
  logic [7:0] advance;

  int n_tests = 0, n_fail = 0;
  logic [15:0] wbuf [6];

  typedef struct packed {
    logic [3:0] cls; logic [3:0] rn; logic [1:0] st;
    logic [31:0] dsp, i0, i1, i2; logic [7:0] adv; logic full;
  } exp_t;
  exp_t eq[$];
  string tq[$];

  always #10 clk = ~clk;

  ea_field_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .field(field), .opsize(opsize),
    .fetch_req(fetch_req), .fetch_ack(fetch_ack), .fetch_err(fetch_err),
    .fetch_data(fetch_data), .done(done), .status(status),
    .mode_class(mode_class), .reg_num(reg_num), .disp(disp),
    .imm0(imm0), .imm1(imm1), .imm2(imm2), .advance(advance)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [5:0] f, input logic [3:0] sz, output int nw);
    exp_t e;
    e = '0; e.full = 1'b1; e.rn = {1'b1, f[2:0]}; nw = 0;
    if (f[5:4] == 2'b00) begin
      e.rn = f[3:0];
    end else if (f == 6'o74) begin
      e.cls = 4'd1;
      if (sz == 1 || sz == 2) nw = 1;
      else if (sz == 4) nw = 2;
      else if (sz == 8) nw = 4;
      else if (sz == 12) nw = 6;
      else e.st = 2'd1;
    end else if (f[5:3] == 3'd7) begin
      e.rn = {1'b0, f[2:0]};
      if (f[2:0] == 0) begin e.cls = 4'd7; nw = 1; end
      else if (f[2:0] == 1) begin e.cls = 4'd8; nw = 2; end
      else if (f[2:0] == 2) begin e.cls = 4'd9; nw = 1; end
      else if (f[2:0] == 3) e.cls = 4'd10;
      else begin e.cls = 4'd15; e.st = 2'd1; end
    end else begin
      e.cls = {1'b0, f[5:3]};
      if (f[5:3] == 3'd5) nw = 1;
    end
    if (e.cls == 5 || e.cls == 7 || e.cls == 9) e.dsp = {{16{wbuf[0][15]}}, wbuf[0]};
    if (e.cls == 8) e.dsp = {wbuf[0], wbuf[1]};
    if (e.cls == 1 && e.st == 0) begin
      if (sz == 1) e.i0 = {{24{wbuf[0][7]}}, wbuf[0][7:0]};
      else if (sz == 2) e.i0 = {{16{wbuf[0][15]}}, wbuf[0]};
      else e.i0 = {wbuf[0], wbuf[1]};
      if (sz >= 8) e.i1 = {wbuf[2], wbuf[3]};
      if (sz == 12) e.i2 = {wbuf[4], wbuf[5]};
    end
    e.adv = 8'(2 * nw);
    return e;
  endfunction

  task automatic run(input logic [5:0] f, input logic [3:0] sz, input int waits,
                     input int fault_idx, input bit poke, input string tag);
    exp_t e;
    int nw;
    e = model(f, sz, nw);
    if (fault_idx >= 0) begin
      e.full = 1'b0; e.st = 2'd2; e.adv = 8'(2 * fault_idx);
    end
    eq.push_back(e); tq.push_back(tag);
    field = f; opsize = sz; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    for (int i = 0; i < nw; i++) begin
      if (fault_idx == i) begin
        fetch_err = 1'b1;
        @(posedge clk); #1;
        fetch_err = 1'b0;
        break;
      end
      for (int w = 0; w < waits; w++) begin
        chk("R10", "fetch_req held while stalled", {31'd0, fetch_req}, 32'd1);
        if (poke) begin start = 1'b1; field = 6'o75; opsize = 4'd3; end
        @(posedge clk); #1;
        start = 1'b0;
      end
      fetch_ack = 1'b1; fetch_data = wbuf[i];
      @(posedge clk); #1;
      fetch_ack = 1'b0;
    end
    @(posedge clk); #1;
    chk(tag, "fetch_req low after done", {31'd0, fetch_req}, 32'd0);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (eq.size() == 0) begin
          chk("R10", "unexpected done", 32'd1, 32'd0);
        end else begin
          exp_t e;
          string t;
          e = eq.pop_front(); t = tq.pop_front();
          chk(t, "status", {30'd0, status}, {30'd0, e.st});
          chk("R8", "advance", {24'd0, advance}, {24'd0, e.adv});
          if (e.full) begin
            chk(t, "class", {28'd0, mode_class}, {28'd0, e.cls});
            chk(t, "reg", {28'd0, reg_num}, {28'd0, e.rn});
            chk(t, "disp", disp, e.dsp);
            chk(t, "imm0", imm0, e.i0);
            chk(t, "imm1", imm1, e.i1);
            chk(t, "imm2", imm2, e.i2);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wbuf[0] = 16'h8123; wbuf[1] = 16'h4567; wbuf[2] = 16'h89AB;
    wbuf[3] = 16'hCDEF; wbuf[4] = 16'h0246; wbuf[5] = 16'hF135;
    repeat (3) @(posedge clk); #1;
    chk("R8", "reset done", {31'd0, done}, 32'd0);
    chk("R8", "reset fetch_req", {31'd0, fetch_req}, 32'd0);
    chk("R8", "reset advance", {24'd0, advance}, 32'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    run(6'o03, 4'd4, 0, -1, 0, "R1");
    run(6'o15, 4'd4, 0, -1, 0, "R1");
    run(6'o22, 4'd4, 0, -1, 0, "R2");
    run(6'o33, 4'd4, 0, -1, 0, "R2");
    run(6'o44, 4'd4, 0, -1, 0, "R2");
    run(6'o65, 4'd4, 0, -1, 0, "R2");
    run(6'o73, 4'd4, 0, -1, 0, "R2");
    run(6'o52, 4'd4, 1, -1, 0, "R3");
    run(6'o72, 4'd4, 0, -1, 0, "R3");
    run(6'o70, 4'd4, 0, -1, 0, "R4");
    run(6'o71, 4'd4, 2, -1, 0, "R4");
    run(6'o75, 4'd4, 0, -1, 0, "R5");
    run(6'o76, 4'd4, 0, -1, 0, "R5");
    run(6'o77, 4'd4, 0, -1, 0, "R5");
    run(6'o74, 4'd3, 0, -1, 0, "R5");
    run(6'o74, 4'd1, 0, -1, 0, "R6");
    run(6'o74, 4'd2, 0, -1, 0, "R6");
    wbuf[0] = 16'h7F80;
    run(6'o74, 4'd1, 0, -1, 0, "R6");
    run(6'o74, 4'd2, 0, -1, 0, "R6");
    wbuf[0] = 16'h8123;
    run(6'o74, 4'd4, 0, -1, 0, "R7");
    run(6'o74, 4'd8, 1, -1, 0, "R7");
    run(6'o74, 4'd12, 2, -1, 0, "R7");
    run(6'o74, 4'd12, 0, 3, 0, "R9");
    run(6'o52, 4'd4, 0, 0, 0, "R9");
    run(6'o71, 4'd4, 3, -1, 1, "R11");
    run(6'o74, 4'd12, 2, -1, 1, "R11");
    repeat (2) @(posedge clk); #1;
    chk("R10", "queue drained", eq.size(), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule